// File: doc/BRIEF.md
# Circular Debug Log Drain Engine

A program running on a guest processor appends text to a ring buffer in shared memory and advances a write-pointer word each time. This engine watches that ring and forwards whatever has not yet been sent to a host link. It repeatedly reads the write-pointer word and compares it with its own read pointer. When there is new data, it hands a DMA request (start address and byte count) to a packet transmitter. After the transmitter reports that the transfer is done, the engine publishes its new read pointer back to shared memory.

When the new data crosses the end of the ring, the engine splits it into two requests. The first covers the bytes from the read pointer up to the end of the data area. The next poll then covers the bytes from offset zero up to the write pointer. Only one transfer is in flight at any time. Dropping `enable` lets an accepted transfer finish and be published, and after that the engine goes quiet. Raising `enable` again clears both pointer words and starts over.

Top module: `dbg_log_drain`

## Requirements
- R1: While reset is held, and while `enable` stays low after reset, `memReq` and `dmaReq` stay low.
- R2: When `enable` rises from the stopped state, the engine clears its internal read pointer and writes 0 to the read-pointer word (0x03FF0004) and then to the write-pointer word (0x03FF0014). After this it begins polling.
- R3: Polling reads the word at 0x03FF0014. A pointer value v is stored in memory as the byte-reversed word {v[7:0], v[15:8], v[23:16], v[31:24]}, both when read and when written.
- R4: If the polled write pointer equals the internal read pointer, no DMA request is made.
- R5: A write pointer of 0xFFE0 (the data-area size) or larger is invalid. On such a poll no request is made and the published word is left unchanged. The value 0xFFDF is still valid.
- R6: If the write pointer is at or above the read pointer rp, the engine requests address 0x03FF0020 + rp with length (write pointer − rp). The read pointer then becomes the write pointer.
- R7: If the write pointer is below rp, the engine requests address 0x03FF0020 + rp with length 0xFFE0 − rp, and the read pointer becomes 0. The following poll then sends the bytes from offset 0 up to the write pointer.
- R8: `dmaReq` is held high, with `dmaAddr` and `dmaLen` unchanged, until a cycle in which `dmaAck` is high. The internal read pointer advances in that cycle.
- R9: The read-pointer word is rewritten with the new read pointer only after `dmaDone`, in the cycle right after it. It is not touched between `dmaAck` and `dmaDone`.
- R10: Between `dmaAck` and `dmaDone` the engine issues no poll read and no new request.
- R11: If `enable` falls while a transfer is in flight, that transfer still completes and is published. After that there are no further reads or requests. A later rise of `enable` restarts the sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the engine; a rise from the stopped state reinitialises it |
| memReq | output | 1 | Memory access strobe, one cycle per access |
| memWe | output | 1 | Access is a write when high, a read when low |
| memAddr | output | 32 | Word address of the access |
| memWdata | output | 32 | Write data (byte-reversed pointer) |
| memRvalid | input | 1 | Read data valid, any cycle after the read strobe |
| memRdata | input | 32 | Read data |
| dmaReq | output | 1 | Transfer request toward the packet transmitter |
| dmaAddr | output | 32 | Transfer start address |
| dmaLen | output | 16 | Transfer length in bytes |
| dmaAck | input | 1 | Transmitter has accepted the request |
| dmaDone | input | 1 | Accepted transfer has completed |

## Verification
The assertions rely on the following properties of the environment:
- The transmitter raises `dmaAck` only while `dmaReq` is high.
- The transmitter pulses `dmaDone` exactly once for each accepted request.
- Memory returns exactly one `memRvalid` per read, no earlier than the cycle after the strobe.

The bench's memory model answers every read one cycle later. Its transmitter model acknowledges only a pending request, after a programmable delay, and then signals done after a second delay. The guest pointer is changed only through the memory model, so every value the engine sees was returned by a genuine read.

// File: rtl/logdrain_pkg.sv
package logdrain_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_CLR_RD,
    ST_CLR_WR,
    ST_POLL,
    ST_WAIT_RD,
    ST_EVAL,
    ST_REQ,
    ST_WAIT_DONE,
    ST_PUB
  } drainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRp;      // zero the internal read pointer
    logic loadWp;     // capture polled write pointer
    logic advRp;      // move read pointer to its next value
    logic selWrWord;  // address the write-pointer word (else read-pointer word)
    logic wrZero;     // write data is zero instead of the read pointer
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] swapBytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/logdrain_dp.sv
module logdrain_dp
  import logdrain_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                PTR_W        = 16,
  parameter int unsigned       BUF_SIZE     = 65504,
  parameter logic [ADDR_W-1:0] RD_WORD_ADDR = 'h03FF0004,
  parameter logic [ADDR_W-1:0] WR_WORD_ADDR = 'h03FF0014,
  parameter logic [ADDR_W-1:0] DATA_BASE    = 'h03FF0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [PTR_W-1:0]  dmaLen,
  output logic              ptrSame,
  output logic              ptrBad
);

  localparam logic [PTR_W-1:0] BUF_LIM = PTR_W'(BUF_SIZE);

  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic              wpHigh;
  logic [WORD_W-1:0] polled;
  logic              wrap;
  logic [PTR_W-1:0]  nextRp;

  assign polled = swapBytes(memRdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wpHigh <= 1'b0;
    end else if (strb.loadWp) begin
      wrPtr  <= polled[PTR_W-1:0];
      wpHigh <= |polled[WORD_W-1:PTR_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdPtr <= '0;
    else if (strb.clrRp)  rdPtr <= '0;
    else if (strb.advRp)  rdPtr <= nextRp;
  end

  assign wrap    = wrPtr < rdPtr;
  assign nextRp  = wrap ? '0 : wrPtr;
  assign dmaLen  = wrap ? (BUF_LIM - rdPtr) : (wrPtr - rdPtr);
  assign dmaAddr = DATA_BASE + ADDR_W'(rdPtr);
  assign ptrSame = !wpHigh && (wrPtr == rdPtr);
  assign ptrBad  = wpHigh || (wrPtr >= BUF_LIM);

  assign memAddr  = strb.selWrWord ? WR_WORD_ADDR : RD_WORD_ADDR;
  assign memWdata = strb.wrZero ? '0 : swapBytes(WORD_W'(rdPtr));

  AST_RP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr < BUF_LIM);  // R6

endmodule

// File: rtl/logdrain_ctrl.sv
module logdrain_ctrl
  import logdrain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      memRvalid,
  input  logic      dmaAck,
  input  logic      dmaDone,
  input  logic      ptrSame,
  input  logic      ptrBad,
  output logic      memReq,
  output logic      memWe,
  output logic      dmaReq,
  output dpStrobe_t strb
);

  drainState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    dmaReq    = 1'b0;
    strb      = '0;
    unique case (state)
      ST_OFF: if (enable) stateNext = ST_CLR_RD;
      ST_CLR_RD: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        strb.wrZero = 1'b1;
        strb.clrRp  = 1'b1;
        stateNext  = ST_CLR_WR;
      end
      ST_CLR_WR: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strb.wrZero    = 1'b1;
        strb.selWrWord = 1'b1;
        stateNext      = ST_POLL;
      end
      ST_POLL: begin
        if (!enable) stateNext = ST_OFF;
        else begin
          memReq         = 1'b1;
          strb.selWrWord = 1'b1;
          stateNext      = ST_WAIT_RD;
        end
      end
      ST_WAIT_RD: if (memRvalid) begin
        strb.loadWp = 1'b1;
        stateNext   = ST_EVAL;
      end
      ST_EVAL: begin
        if (!enable)                stateNext = ST_OFF;
        else if (ptrSame || ptrBad) stateNext = ST_POLL;
        else                        stateNext = ST_REQ;
      end
      ST_REQ: begin
        dmaReq = 1'b1;
        if (dmaAck) begin
          strb.advRp = 1'b1;
          stateNext  = ST_WAIT_DONE;
        end
      end
      ST_WAIT_DONE: if (dmaDone) stateNext = ST_PUB;
      ST_PUB: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stateNext = enable ? ST_POLL : ST_OFF;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck |=> dmaReq);  // R8

  AST_OFF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PUB) && !enable |=> !memReq && !dmaReq);  // R11

endmodule

// File: rtl/dbg_log_drain.sv
module dbg_log_drain
  import logdrain_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                PTR_W        = 16,
  parameter int unsigned       BUF_SIZE     = 65504,
  parameter logic [ADDR_W-1:0] RD_WORD_ADDR = 'h03FF0004,
  parameter logic [ADDR_W-1:0] WR_WORD_ADDR = 'h03FF0014,
  parameter logic [ADDR_W-1:0] DATA_BASE    = 'h03FF0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [WORD_W-1:0] memRdata,
  output logic              dmaReq,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [PTR_W-1:0]  dmaLen,
  input  logic              dmaAck,
  input  logic              dmaDone
);

  dpStrobe_t strb;
  logic      ptrSame;
  logic      ptrBad;

  logdrain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .memRvalid(memRvalid),
    .dmaAck(dmaAck), .dmaDone(dmaDone), .ptrSame(ptrSame), .ptrBad(ptrBad),
    .memReq(memReq), .memWe(memWe), .dmaReq(dmaReq), .strb(strb)
  );

  logdrain_dp #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .BUF_SIZE(BUF_SIZE),
    .RD_WORD_ADDR(RD_WORD_ADDR), .WR_WORD_ADDR(WR_WORD_ADDR), .DATA_BASE(DATA_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .ptrSame(ptrSame), .ptrBad(ptrBad)
  );

  // port-level checks
  logic            outstanding;
  logic [ADDR_W:0] endOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outstanding <= 1'b0;
    else if (dmaReq && dmaAck) outstanding <= 1'b1;
    else if (dmaDone)          outstanding <= 1'b0;
  end

  assign endOffset = ({1'b0, dmaAddr} - {1'b0, DATA_BASE}) + (ADDR_W+1)'(dmaLen);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck |=> $stable(dmaAddr) && $stable(dmaLen));  // R8

  AST_LEN_IN_BUF: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (dmaLen != '0) && (endOffset <= (ADDR_W+1)'(BUF_SIZE)));  // R7

  AST_PUB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && (memAddr == RD_WORD_ADDR) && (memWdata != '0) |-> $past(dmaDone));  // R9

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !dmaReq && !(memReq && !memWe));  // R10

endmodule

// File: tb/dbg_log_drain_bench.sv
`timescale 1ns/1ps
module dbg_log_drain_bench;

  localparam int unsigned SIZE = 65504;
  localparam logic [31:0] RD_A = 32'h03FF0004;
  localparam logic [31:0] WR_A = 32'h03FF0014;
  localparam logic [31:0] BASE = 32'h03FF0020;

  logic clk = 0, rstN = 0, enable = 0;
  logic memRvalid = 0, dmaAck = 0, dmaDone = 0;
  logic [31:0] memRdata = 0;
  logic memReq, memWe, dmaReq;
  logic [31:0] memAddr, memWdata, dmaAddr;
  logic [15:0] dmaLen;

  dbg_log_drain u_dbg_log_drain (
    .clk(clk), .rstN(rstN), .enable(enable),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaAck(dmaAck), .dmaDone(dmaDone)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] rdWord, wrWord, lastWp, wordAtAck;
  int unsigned rpModel = 0;
  int xfers = 0, reads = 0;
  bit inFlight = 0, activity = 0, pendRd = 0;
  int ackDelay = 2, doneDelay = 6;
  logic [31:0] reqAddr[$];
  int unsigned reqLen[$];

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, two pointer words
  always @(negedge clk) begin
    memRvalid = pendRd;
    if (pendRd) begin
      memRdata = wrWord;
      lastWp   = rev(wrWord);
      reads++;
    end
    pendRd = rstN && memReq && !memWe;
    if (inFlight && ((memReq && !memWe) || dmaReq)) activity = 1;
    if (memReq && !memWe && memAddr != WR_A)
      check(0, "R3", "poll address", memAddr, WR_A);
    if (memReq && memWe) begin
      if (memAddr == RD_A) begin
        check(memWdata == rev(rpModel), "R9", "published word", memWdata, rev(rpModel));
        rdWord = memWdata;
      end else if (memAddr == WR_A) begin
        check(memWdata == 0, "R2", "write-pointer clear", memWdata, 0);
        wrWord = memWdata;
      end else
        check(0, "R2", "write address", memAddr, RD_A);
    end
  end

  // transmitter model
  initial begin
    forever begin
      @(negedge clk);
      if (dmaReq === 1'b1) begin
        bit wrapCase;
        int unsigned eLen, eNext;
        logic [31:0] a0;
        int unsigned l0;
        check(lastWp != rpModel && lastWp < SIZE, "R4", "request only with new valid data", lastWp, rpModel);
        wrapCase = lastWp < rpModel;
        eLen  = wrapCase ? SIZE - rpModel : lastWp - rpModel;
        eNext = wrapCase ? 0 : lastWp;
        check(dmaAddr == BASE + rpModel, "R6", "request address", dmaAddr, BASE + rpModel);
        check(dmaLen == eLen[15:0], wrapCase ? "R7" : "R6", "request length", dmaLen, eLen);
        a0 = dmaAddr; l0 = dmaLen;
        reqAddr.push_back(a0); reqLen.push_back(l0);
        for (int i = 0; i < ackDelay; i++) begin
          @(negedge clk);
          check(dmaReq && dmaAddr == a0 && dmaLen == l0[15:0], "R8", "request held", dmaAddr, a0);
        end
        dmaAck = 1;
        @(negedge clk);
        dmaAck = 0;
        check(!dmaReq, "R8", "request drops after accept", dmaReq, 0);
        rpModel = eNext; wordAtAck = rdWord; inFlight = 1; activity = 0;
        repeat (doneDelay) @(negedge clk);
        check(rdWord == wordAtAck, "R9", "word untouched before done", rdWord, wordAtAck);
        check(!activity, "R10", "no poll or request in flight", activity, 0);
        dmaDone = 1; inFlight = 0;
        @(negedge clk);
        dmaDone = 0;
        xfers++;
      end
    end
  end

  task automatic waitXfers(input int n);
    while (xfers < n) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", xfers, 0);
    finishRun();
  end

  initial begin
    int x0, r0;
    rdWord = 32'hDEADBEEF; wrWord = 32'hA5A5A5A5;
    repeat (4) @(negedge clk);
    check(!memReq && !dmaReq, "R1", "quiet in reset", {memReq, dmaReq}, 0);
    rstN = 1;
    repeat (12) @(negedge clk);
    check(!memReq && !dmaReq && rdWord == 32'hDEADBEEF, "R1", "quiet while disabled", rdWord, 32'hDEADBEEF);

    // start
    rpModel = 0; enable = 1;
    repeat (8) @(negedge clk);
    check(rdWord == 0, "R2", "read word cleared", rdWord, 0);
    check(wrWord == 0, "R2", "write word cleared", wrWord, 0);

    // empty ring
    x0 = xfers; r0 = reads;
    repeat (60) @(negedge clk);
    check(xfers == x0, "R4", "no transfer when equal", xfers, x0);
    check(reads > r0 + 5, "R3", "polling continues", reads, r0 + 5);

    // straight spans
    wrWord = rev(32'h100);
    waitXfers(x0 + 1);
    check(reqAddr[$] == BASE && reqLen[$] == 32'h100, "R6", "first span", reqLen[$], 32'h100);
    check(rdWord == 32'h00010000, "R3", "published byte order", rdWord, 32'h00010000);
    ackDelay = 5;
    wrWord = rev(32'h300);
    waitXfers(x0 + 2);
    check(reqAddr[$] == BASE + 32'h100 && reqLen[$] == 32'h200, "R6", "second span", reqAddr[$], BASE + 32'h100);

    // invalid pointers
    x0 = xfers;
    wrWord = rev(32'hFFE0);
    repeat (60) @(negedge clk);
    check(xfers == x0 && rdWord == rev(32'h300), "R5", "size value ignored", xfers, x0);
    wrWord = rev(32'h0001_0005);
    repeat (60) @(negedge clk);
    check(xfers == x0 && rdWord == rev(32'h300), "R5", "high bits ignored", xfers, x0);

    // wrap split
    ackDelay = 1;
    wrWord = rev(32'h80);
    waitXfers(x0 + 2);
    check(reqAddr[$-1] == BASE + 32'h300 && reqLen[$-1] == SIZE - 32'h300, "R7", "tail part", reqLen[$-1], SIZE - 32'h300);
    check(reqAddr[$] == BASE && reqLen[$] == 32'h80, "R7", "restart from zero", reqLen[$], 32'h80);
    check(rdWord == 32'h80000000, "R7", "pointer after wrap", rdWord, 32'h80000000);

    // last valid value
    wrWord = rev(32'hFFDF);
    waitXfers(x0 + 3);
    check(reqAddr[$] == BASE + 32'h80 && reqLen[$] == 32'hFF5F, "R5", "edge value accepted", reqLen[$], 32'hFF5F);
    wrWord = rev(32'h10);
    waitXfers(x0 + 5);
    check(reqLen[$-1] == 1 && reqLen[$] == 32'h10, "R7", "one-byte tail then head", reqLen[$-1], 1);

    // disable while in flight
    doneDelay = 20; x0 = xfers;
    wrWord = rev(32'h40);
    while (!inFlight) @(negedge clk);
    enable = 0;
    waitXfers(x0 + 1);
    check(rdWord == rev(32'h40), "R11", "in-flight transfer published", rdWord, rev(32'h40));
    r0 = reads; x0 = xfers;
    wrWord = rev(32'h90);
    repeat (60) @(negedge clk);
    check(reads == r0 && xfers == x0 && !memReq && !dmaReq, "R11", "quiet after stop", reads, r0);

    // restart
    doneDelay = 4; rpModel = 0; enable = 1;
    repeat (6) @(negedge clk);
    check(rdWord == 0 && wrWord == 0, "R11", "restart clears words", rdWord, 0);
    wrWord = rev(32'h20);
    waitXfers(x0 + 1);
    check(reqAddr[$] == BASE && reqLen[$] == 32'h20, "R11", "pointer restarted at zero", reqAddr[$], BASE);

    finishRun();
  end

endmodule